// File: doc/BRIEF.md
# Two-level translation table walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table held in memory. A request carries the virtual address, the upper bits of the table base and a flag that permits 1 KB tiny pages. The walker then fetches one or two descriptors through a read port that allows one outstanding read. The first descriptor is either a section, which is a final translation, or a pointer to a coarse or fine second-level table. The second descriptor names a large page (64 KB), a small page (4 KB) or a tiny page (1 KB).

Every walk ends with a one-cycle `done` pulse. At that point the physical address, the cacheable/bufferable pair, the domain, the access-permission field and the page kind are valid. A walk that meets an illegal type code raises `fault`. A walk whose descriptor fetch returns an error raises `bus_err`. The result stays on the outputs until the next walk finishes. Caching of translations, permission checks and domain checks belong to the surrounding logic.

Top module: `ptw_walker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After reset, `done`, `fault` and `bus_err` are 0, `mem_req_valid` is 0 and `req_ready` is 1.
- R2: The first read goes to `{req_tbase, va[31:20], 2'b00}`. `mem_req_valid` and `mem_addr` hold steady until `mem_req_ready` is seen. While a read waits for its response, `mem_req_valid` is 0.
- R3: A first-level type (bits [1:0]) of 00 ends the walk with `fault`=1 and no second read.
- R4: A first-level type of 11 while `req_tiny_en` is 0 ends the walk with `fault`=1 and no second read.
- R5: A first-level type of 10 (section) ends the walk with no second read. The results are `pa = {d[31:20], va[19:0]}`, `cb = d[3:2]`, `ap = {6'b0, d[11:10]}` and `kind` = 0. In every walk that is not faulted, `domain` is first-level bits [8:5].
- R6: A first-level type of 01 (coarse) issues a second read at `{d[31:10], va[19:12], 2'b00}`.
- R7: A first-level type of 11 with `req_tiny_en`=1 (fine) issues a second read at `{d[31:12], va[19:10], 2'b00}`.
- R8: A second-level type of 00 ends the walk with `fault`=1.
- R9: A second-level type of 01 (large) gives `pa = {d[31:16], va[15:0]}`, `ap = d[11:4]`, `cb = d[3:2]` and `kind` = 1.
- R10: A second-level type of 10 (small) gives `pa = {d[31:12], va[11:0]}`, `ap = d[11:4]`, `cb = d[3:2]` and `kind` = 2.
- R11: A second-level type of 11 (tiny) gives `pa = {d[31:10], va[9:0]}`, `ap = {6'b0, d[5:4]}`, `cb = d[3:2]` and `kind` = 3.
- R12: A response with `mem_rsp_err`=1 on either read ends the walk at once. The walk then shows `bus_err`=1 and `fault`=0, and makes no further read.
- R13: `req_ready` is 1 only while idle, and a request offered while busy is ignored. `done` lasts exactly one cycle. A faulted or errored walk shows 0 on `pa`, `cb`, `domain`, `ap` and `kind`. The results hold until the next walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request taken |
| req_va | input | 32 | Virtual address |
| req_tbase | input | 18 | Table base bits [31:14] |
| req_tiny_en | input | 1 | Permit fine tables and tiny pages |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Read request acknowledged |
| mem_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Read returned an error |
| done | output | 1 | One-cycle walk-complete pulse |
| fault | output | 1 | Translation fault |
| bus_err | output | 1 | Descriptor fetch error |
| pa | output | 32 | Physical address |
| cb | output | 2 | Cacheable/bufferable bits |
| domain | output | 4 | Domain from first-level descriptor |
| ap | output | 8 | Access-permission field |
| kind | output | 2 | 0 section, 1 large, 2 small, 3 tiny |

## Verification
The hardest case to reach from the ports is an error on the second read. The first descriptor must already have chosen a coarse or fine table, and for fine the tiny flag must be set. A single error on the first read never gets that far. The bench's memory responder therefore sweeps every first-level type against every second-level type, both settings of the tiny flag and three error placements. It stretches the acknowledge and response delays per walk, and it offers stray requests while a read is pending.

// File: rtl/ptw_walker.sv
module ptw_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [17:0] req_tbase,
  input  logic        req_tiny_en,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        done,
  output logic        fault,
  output logic        bus_err,
  output logic [31:0] pa,
  output logic [1:0]  cb,
  output logic [3:0]  domain,
  output logic [7:0]  ap,
  output logic [1:0]  kind
);
  localparam logic [1:0] T_NONE = 2'b00;
  localparam logic [1:0] T_LO   = 2'b01;
  localparam logic [1:0] T_MID  = 2'b10;
  localparam logic [1:0] T_HI   = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_L1REQ, S_L1WAIT, S_L2REQ, S_L2WAIT} st_t;

  st_t         st;
  logic [19:0] va_q;
  logic        tiny_q;
  logic [3:0]  dom_q;

  logic        fin, go_l2, f_fault, f_berr;
  logic [31:0] f_pa, l2_addr;
  logic [1:0]  f_cb, f_kind;
  logic [3:0]  f_dom;
  logic [7:0]  f_ap;

  wire [31:0] d = mem_rsp_data;
  wire        l1_rsp = (st == S_L1WAIT) && mem_rsp_valid;
  wire        l2_rsp = (st == S_L2WAIT) && mem_rsp_valid;

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_L1REQ) || (st == S_L2REQ);

  always_comb begin
    fin = 1'b0; go_l2 = 1'b0; f_fault = 1'b0; f_berr = 1'b0;
    f_pa = '0; f_cb = '0; f_dom = '0; f_ap = '0; f_kind = '0;
    l2_addr = '0;
    if (l1_rsp) begin
      if (mem_rsp_err) begin
        fin = 1'b1; f_berr = 1'b1;
      end else begin
        case (d[1:0])
          T_NONE: begin fin = 1'b1; f_fault = 1'b1; end
          T_MID: begin
            fin = 1'b1;
            f_pa = {d[31:20], va_q[19:0]};
            f_cb = d[3:2];
            f_dom = d[8:5];
            f_ap = {6'b0, d[11:10]};
            f_kind = 2'd0;
          end
          T_LO: begin
            go_l2 = 1'b1;
            l2_addr = {d[31:10], va_q[19:12], 2'b00};
          end
          T_HI: begin
            if (!tiny_q) begin
              fin = 1'b1; f_fault = 1'b1;
            end else begin
              go_l2 = 1'b1;
              l2_addr = {d[31:12], va_q[19:10], 2'b00};
            end
          end
          default: ;
        endcase
      end
    end else if (l2_rsp) begin
      fin = 1'b1;
      if (mem_rsp_err) begin
        f_berr = 1'b1;
      end else if (d[1:0] == T_NONE) begin
        f_fault = 1'b1;
      end else begin
        f_cb = d[3:2];
        f_dom = dom_q;
        case (d[1:0])
          T_LO: begin
            f_pa = {d[31:16], va_q[15:0]}; f_ap = d[11:4]; f_kind = 2'd1;
          end
          T_MID: begin
            f_pa = {d[31:12], va_q[11:0]}; f_ap = d[11:4]; f_kind = 2'd2;
          end
          default: begin
            f_pa = {d[31:10], va_q[9:0]}; f_ap = {6'b0, d[5:4]}; f_kind = 2'd3;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0; tiny_q <= 1'b0; dom_q <= '0; mem_addr <= '0;
      done <= 1'b0; fault <= 1'b0; bus_err <= 1'b0;
      pa <= '0; cb <= '0; domain <= '0; ap <= '0; kind <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_va[19:0];
          tiny_q <= req_tiny_en;
          mem_addr <= {req_tbase, req_va[31:20], 2'b00};
          st <= S_L1REQ;
        end
        S_L1REQ: if (mem_req_ready) st <= S_L1WAIT;
        S_L2REQ: if (mem_req_ready) st <= S_L2WAIT;
        default: ;
      endcase
      if (l1_rsp) dom_q <= d[8:5];
      if (go_l2) begin
        mem_addr <= l2_addr;
        st <= S_L2REQ;
      end
      if (fin) begin
        st <= S_IDLE;
        done <= 1'b1;
        fault <= f_fault; bus_err <= f_berr;
        pa <= f_pa; cb <= f_cb; domain <= f_dom; ap <= f_ap; kind <= f_kind;
      end
    end
  end
endmodule

module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_addr,
  input logic        done,
  input logic        fault,
  input logic        bus_err,
  input logic [31:0] pa
);
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));
  // R13
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> !req_ready);
  // R12
  berr_clean_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_err |-> !fault && pa == 32'd0);
  // R3
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n) fault |-> pa == 32'd0);
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_tiny_en = 0;
  logic [31:0] req_va = 0;
  logic [17:0] req_tbase = 0;
  logic mem_req_ready = 0, mem_rsp_valid = 0, mem_rsp_err = 0;
  logic [31:0] mem_rsp_data = 0;
  logic req_ready, mem_req_valid, done, fault, bus_err;
  logic [31:0] mem_addr, pa;
  logic [1:0] cb, kind;
  logic [3:0] domain;
  logic [7:0] ap;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  ptw_walker u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic serve(input logic [31:0] addr, input logic [31:0] data, input bit err,
                       input int gap, input int lat, input string req);
    int n = 0;
    while (!mem_req_valid && n < 20) begin @(negedge clk); n++; end
    chk(mem_req_valid, req, {31'b0, mem_req_valid}, 1);
    chk(mem_addr == addr, req, mem_addr, addr);
    for (int g = 0; g < gap; g++) begin
      req_valid = 1; req_va = ~req_va;
      @(negedge clk);
      chk(mem_req_valid && mem_addr == addr, "R2 hold", mem_addr, addr);
      chk(!req_ready, "R13 busy", {31'b0, req_ready}, 0);
    end
    req_valid = 0;
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    chk(!mem_req_valid, "R2 single", {31'b0, mem_req_valid}, 0);
    for (int l = 0; l < lat; l++) @(negedge clk);
    mem_rsp_valid = 1; mem_rsp_data = data; mem_rsp_err = err;
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_err = 0;
  endtask

  task automatic walk(input logic [31:0] va, input logic [17:0] tb, input bit tiny,
                      input logic [31:0] d1, input logic [31:0] d2, input int errm, input int n);
    logic [31:0] l1a, l2a, epa;
    logic [1:0] ecb, ekind;
    logic [3:0] edom;
    logic [7:0] eap;
    bit two, ef, eb;
    string tag;
    l1a = {tb, va[31:20], 2'b00};
    two = 0; ef = 0; eb = 0; epa = 0; ecb = 0; ekind = 0; edom = 0; eap = 0; l2a = 0;
    tag = "R5";
    if (errm == 1) begin eb = 1; tag = "R12"; end
    else if (d1[1:0] == 2'b00) begin ef = 1; tag = "R3"; end
    else if (d1[1:0] == 2'b10) begin
      epa = {d1[31:20], va[19:0]}; ecb = d1[3:2]; eap = {6'b0, d1[11:10]}; edom = d1[8:5];
    end else if (d1[1:0] == 2'b11 && !tiny) begin ef = 1; tag = "R4"; end
    else begin
      two = 1;
      l2a = (d1[1:0] == 2'b01) ? {d1[31:10], va[19:12], 2'b00} : {d1[31:12], va[19:10], 2'b00};
      if (errm == 2) begin eb = 1; tag = "R12"; end
      else if (d2[1:0] == 2'b00) begin ef = 1; tag = "R8"; end
      else begin
        edom = d1[8:5]; ecb = d2[3:2];
        case (d2[1:0])
          2'b01: begin epa = {d2[31:16], va[15:0]}; eap = d2[11:4]; ekind = 1; tag = "R9"; end
          2'b10: begin epa = {d2[31:12], va[11:0]}; eap = d2[11:4]; ekind = 2; tag = "R10"; end
          default: begin epa = {d2[31:10], va[9:0]}; eap = {6'b0, d2[5:4]}; ekind = 3; tag = "R11"; end
        endcase
      end
    end
    @(negedge clk);
    chk(req_ready, "R13 idle", {31'b0, req_ready}, 1);
    req_valid = 1; req_va = va; req_tbase = tb; req_tiny_en = tiny;
    @(negedge clk);
    req_valid = 0;
    serve(l1a, d1, errm == 1, n % 3, n % 2, "R2 l1addr");
    if (two) begin
      chk(!done, "R13 early", {31'b0, done}, 0);
      serve(l2a, d2, errm == 2, (n + 1) % 3, (n + 1) % 2, d1[1:0] == 2'b01 ? "R6" : "R7");
    end
    chk(done, {tag, " done"}, {31'b0, done}, 1);
    chk(fault == ef, {tag, " fault"}, {31'b0, fault}, {31'b0, ef});
    chk(bus_err == eb, {tag, " bus_err"}, {31'b0, bus_err}, {31'b0, eb});
    chk(pa == epa, {tag, " pa"}, pa, epa);
    chk(cb == ecb && kind == ekind, {tag, " cb/kind"}, {28'b0, cb, kind}, {28'b0, ecb, ekind});
    chk(domain == edom && ap == eap, {tag, " dom/ap"}, {20'b0, domain, ap}, {20'b0, edom, eap});
    @(negedge clk);
    chk(!done, "R13 pulse", {31'b0, done}, 0);
    chk(!mem_req_valid, "R12 no further read", {31'b0, mem_req_valid}, 0);
    chk(pa == epa && fault == ef, "R13 hold", pa, epa);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] vas [3];
    int n = 0;
    vas[0] = 32'h1234_5678; vas[1] = 32'hFFFF_FFFF; vas[2] = 32'h8001_0A5C;
    repeat (3) @(negedge clk);
    chk(!done && !fault && !bus_err, "R1 flags", {29'b0, done, fault, bus_err}, 0);
    chk(req_ready && !mem_req_valid, "R1 ports", {30'b0, req_ready, mem_req_valid}, 2);
    rst_n = 1;
    for (int v = 0; v < 3; v++)
      for (int t1 = 0; t1 < 4; t1++)
        for (int tiny = 0; tiny < 2; tiny++)
          for (int t2 = 0; t2 < 4; t2++)
            for (int e = 0; e < 3; e++) begin
              logic [31:0] d1, d2;
              d1 = ((32'h9E37_79B9 * (v + 1) + 32'h0101_0101 * t2) & ~32'h3) | t1;
              d2 = ((32'h7F4A_7C15 * (v + 3) ^ (32'h0011_0000 * e)) & ~32'h3) | t2;
              walk(vas[v], 18'h2AB5C ^ (18'h1111 * v), tiny[0], d1, d2, e, n);
              n++;
            end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule